// File: doc/BRIEF.md
# Single-Bit Manipulation Execution Unit

This execution unit carries out one bit operation on a byte-wide operand per request. There are five operations. Set forces the chosen bit to 1, clear forces it to 0 and invert flips it. Test reports the chosen bit through the zero flag. Load-to-carry copies the chosen bit into the carry flag. The operand can live in three places: the low byte of a general register, a memory byte whose address is held in a register, or a memory byte at an 8-bit absolute address. The bit number comes either from a 3-bit immediate field or from the low bits of another register.

A decoder outside the block presents the decoded fields together with a one-cycle `start` strobe. The unit reads registers through one combinational read port and writes a byte back through a write port. It reaches memory through a synchronous port whose read data is valid in the cycle after the read strobe. The zero and carry values are offered together with per-flag update enables, which the surrounding condition-code register latches. `done` marks the last cycle of every operation.

Controller states and transitions:
- `ST_IDLE` goes to `ST_REG_IDX` on start with a register operand, and to `ST_MEM_IDX` on start with a memory operand.
- Register path: `ST_REG_IDX` -> `ST_REG_DONE` -> `ST_IDLE`.
- Memory path, common part: `ST_MEM_IDX` -> `ST_MEM_ADDR` -> `ST_MEM_RD` -> `ST_MEM_CAP`.
- From `ST_MEM_CAP`, a modifying operation continues with `ST_MEM_MOD` -> `ST_MEM_WR` -> `ST_MEM_SETTLE` -> `ST_MEM_FIN`.
- From `ST_MEM_CAP`, test and load-to-carry continue with `ST_MEM_EVAL` -> `ST_MEM_FIN`.
- `ST_MEM_FIN` -> `ST_IDLE`.

Top module: `bitop_unit`

## Requirements
- R1: Set (op_code 0), clear (op_code 1) and invert (op_code 2) change only the selected bit of the operand and write the full byte back to its location. Bit number 0 is the least significant bit.
- R2: Test (op_code 3) drives flag_z with the inverse of the selected bit and flag_z_we=1 in the done cycle. It never writes the operand.
- R3: Load-to-carry (op_code 4) drives flag_c with the selected bit and flag_c_we=1 in the done cycle. It never writes the operand.
- R4: Set, clear and invert never assert flag_z_we or flag_c_we.
- R5: With a register operand (opnd_loc 0), done is high in the 2nd cycle after the clock edge that samples start. The byte is written through reg_we in that same cycle.
- R6: With a memory operand and op_code 0 to 2, done is high in cycle 8. There is exactly one read (mem_re in cycle 3) and exactly one write (mem_we in cycle 6), both to the same address.
- R7: With a memory operand and op_code 3 or 4, done is high in cycle 6. There is exactly one read (mem_re in cycle 3) and no write.
- R8: When idx_from_reg=1, the bit number is bits [2:0] of register idx_reg_sel, and all its upper bits are ignored. When idx_from_reg=0, the bit number is idx_imm.
- R9: opnd_loc 1 uses the full register opnd_reg_sel as the memory address. opnd_loc 2 uses abs_addr with every upper address bit forced to 1.
- R10: A start that arrives while an operation is running is ignored: it changes neither the result nor the length of that operation, and it produces no second done.
- R11: done lasts exactly one cycle per operation. Flag enables and writes occur only in the done cycle, and never both flag enables at once.
- R12: After reset, done, reg_we, mem_re, mem_we, flag_z_we and flag_c_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled only when idle |
| op_code | input | 3 | 0 set, 1 clear, 2 invert, 3 test, 4 load-to-carry |
| opnd_loc | input | 2 | 0 register, 1 memory via register pointer, 2 memory at absolute address |
| idx_from_reg | input | 1 | 1: bit number from a register, 0: from idx_imm |
| idx_imm | input | 3 | Immediate bit number |
| idx_reg_sel | input | RSEL_W | Register holding the bit number |
| opnd_reg_sel | input | RSEL_W | Operand register or pointer register |
| abs_addr | input | 8 | Absolute short address |
| reg_raddr | output | RSEL_W | Register read select |
| reg_rdata | input | ADDR_W | Register read data (combinational) |
| reg_we | output | 1 | Register byte write enable |
| reg_waddr | output | RSEL_W | Register write select |
| reg_wdata | output | 8 | Byte written into the low bits of the register |
| mem_addr | output | ADDR_W | Memory address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after mem_re |
| flag_z | output | 1 | Zero flag value |
| flag_z_we | output | 1 | Zero flag update enable |
| flag_c | output | 1 | Carry flag value |
| flag_c_we | output | 1 | Carry flag update enable |
| done | output | 1 | Final-cycle pulse |

## Verification
The assertions assume that op_code stays within 0 to 4 and opnd_loc within 0 to 2. They also assume that read data from a register is available in the same cycle as its select, and that memory delivers its byte exactly one cycle after mem_re. The bench keeps to these assumptions: it only issues legal encodings, its register model answers combinationally, and its memory model registers the read byte on the edge that samples mem_re. Start is the one input driven against the rules. It is held high through a whole register operation while the other fields change, to exercise the case where a start is ignored.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [2:0] {
        OP_SET = 3'd0,
        OP_CLR = 3'd1,
        OP_INV = 3'd2,
        OP_TST = 3'd3,
        OP_LDC = 3'd4
    } bit_op_e;

    typedef enum logic [1:0] {
        LOC_REG = 2'd0,
        LOC_PTR = 2'd1,
        LOC_ABS = 2'd2
    } opnd_loc_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REG_IDX,
        ST_REG_DONE,
        ST_MEM_IDX,
        ST_MEM_ADDR,
        ST_MEM_RD,
        ST_MEM_CAP,
        ST_MEM_MOD,
        ST_MEM_WR,
        ST_MEM_SETTLE,
        ST_MEM_EVAL,
        ST_MEM_FIN
    } fsm_st_e;

    function automatic logic op_modifies(bit_op_e op);
        return (op == OP_SET) || (op == OP_CLR) || (op == OP_INV);
    endfunction

endpackage

// File: rtl/bitop_idx_sel.sv
module bitop_idx_sel #(
    parameter int IDX_W = 3
) (
    input  logic             from_reg,
    input  logic [IDX_W-1:0] imm,
    input  logic [IDX_W-1:0] reg_low,
    output logic [IDX_W-1:0] bitno
);
    // Only the low bits of the register ever reach this point.
    always_comb begin
        bitno = from_reg ? reg_low : imm;
    end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = $clog2(BYTE_W)
) (
    input  bit_op_e           op,
    input  logic [IDX_W-1:0]  bitno,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout,
    output logic              sel_bit
);
    for (genvar i = 0; i < BYTE_W; i++) begin : g_lane
        logic hit;
        assign hit = (bitno == IDX_W'(i));
        always_comb begin
            dout[i] = din[i];
            if (hit) begin
                unique case (op)
                    OP_SET:  dout[i] = 1'b1;
                    OP_CLR:  dout[i] = 1'b0;
                    OP_INV:  dout[i] = ~din[i];
                    default: dout[i] = din[i];
                endcase
            end
        end
    end

    assign sel_bit = din[bitno];
endmodule

// File: rtl/bitop_fsm.sv
module bitop_fsm
    import bitop_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    start_mem,
    input  logic    modifies,
    output fsm_st_e state,
    output logic    busy,
    output logic    done
);
    fsm_st_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (start) nxt = start_mem ? ST_MEM_IDX : ST_REG_IDX;
            ST_REG_IDX:    nxt = ST_REG_DONE;
            ST_REG_DONE:   nxt = ST_IDLE;
            ST_MEM_IDX:    nxt = ST_MEM_ADDR;
            ST_MEM_ADDR:   nxt = ST_MEM_RD;
            ST_MEM_RD:     nxt = ST_MEM_CAP;
            ST_MEM_CAP:    nxt = modifies ? ST_MEM_MOD : ST_MEM_EVAL;
            ST_MEM_MOD:    nxt = ST_MEM_WR;
            ST_MEM_WR:     nxt = ST_MEM_SETTLE;
            ST_MEM_SETTLE: nxt = ST_MEM_FIN;
            ST_MEM_EVAL:   nxt = ST_MEM_FIN;
            ST_MEM_FIN:    nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_REG_DONE) || (state == ST_MEM_FIN);
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int RSEL_W = 4,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op_code,
    input  logic [1:0]        opnd_loc,
    input  logic              idx_from_reg,
    input  logic [2:0]        idx_imm,
    input  logic [RSEL_W-1:0] idx_reg_sel,
    input  logic [RSEL_W-1:0] opnd_reg_sel,
    input  logic [7:0]        abs_addr,
    output logic [RSEL_W-1:0] reg_raddr,
    input  logic [ADDR_W-1:0] reg_rdata,
    output logic              reg_we,
    output logic [RSEL_W-1:0] reg_waddr,
    output logic [7:0]        reg_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              flag_z,
    output logic              flag_z_we,
    output logic              flag_c,
    output logic              flag_c_we,
    output logic              done
);
    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);
    localparam int ABS_W  = 8;
    localparam int HI_W   = ADDR_W - ABS_W;

    fsm_st_e           state;
    logic              busy;
    logic              accept;
    bit_op_e           op_q;
    opnd_loc_e         loc_q;
    logic              idx_from_reg_q;
    logic [IDX_W-1:0]  idx_imm_q;
    logic [RSEL_W-1:0] idx_reg_q;
    logic [RSEL_W-1:0] opnd_reg_q;
    logic [ABS_W-1:0]  abs_q;
    logic [IDX_W-1:0]  bitno_q;
    logic [IDX_W-1:0]  bitno_nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] byte_q;
    logic [BYTE_W-1:0] alu_in;
    logic [BYTE_W-1:0] alu_out;
    logic              sel_bit;

    assign accept = start && !busy;

    bitop_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_mem (opnd_loc != LOC_REG),
        .modifies  (op_modifies(op_q)),
        .state     (state),
        .busy      (busy),
        .done      (done)
    );

    bitop_idx_sel #(.IDX_W(IDX_W)) u_idx (
        .from_reg (idx_from_reg_q),
        .imm      (idx_imm_q),
        .reg_low  (reg_rdata[IDX_W-1:0]),
        .bitno    (bitno_nxt)
    );

    bitop_alu #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_alu (
        .op      (op_q),
        .bitno   (bitno_q),
        .din     (alu_in),
        .dout    (alu_out),
        .sel_bit (sel_bit)
    );

    // Request fields, captured only when a start is accepted.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q           <= OP_SET;
            loc_q          <= LOC_REG;
            idx_from_reg_q <= 1'b0;
            idx_imm_q      <= '0;
            idx_reg_q      <= '0;
            opnd_reg_q     <= '0;
            abs_q          <= '0;
        end else if (accept) begin
            op_q           <= bit_op_e'(op_code);
            loc_q          <= opnd_loc_e'(opnd_loc);
            idx_from_reg_q <= idx_from_reg;
            idx_imm_q      <= idx_imm;
            idx_reg_q      <= idx_reg_sel;
            opnd_reg_q     <= opnd_reg_sel;
            abs_q          <= abs_addr;
        end
    end

    // Working registers: bit number, address and byte.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitno_q <= '0;
            addr_q  <= '0;
            byte_q  <= '0;
        end else begin
            unique case (state)
                ST_REG_IDX, ST_MEM_IDX: bitno_q <= bitno_nxt;
                ST_MEM_ADDR: begin
                    if (loc_q == LOC_PTR) addr_q <= reg_rdata;
                    else                  addr_q <= {{HI_W{1'b1}}, abs_q};
                end
                ST_MEM_CAP:  byte_q <= mem_rdata;
                ST_MEM_MOD:  byte_q <= alu_out;
                default: ;
            endcase
        end
    end

    assign alu_in    = (state == ST_REG_DONE) ? reg_rdata[BYTE_W-1:0] : byte_q;
    assign reg_waddr = opnd_reg_q;
    assign reg_wdata = alu_out;
    assign mem_addr  = addr_q;
    assign mem_wdata = byte_q;
    assign flag_z    = ~sel_bit;
    assign flag_c    = sel_bit;

    // Port strobes per state.
    always_comb begin
        reg_raddr = '0;
        reg_we    = 1'b0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        flag_z_we = 1'b0;
        flag_c_we = 1'b0;
        unique case (state)
            ST_REG_IDX, ST_MEM_IDX: reg_raddr = idx_reg_q;
            ST_MEM_ADDR:            reg_raddr = opnd_reg_q;
            ST_REG_DONE: begin
                reg_raddr = opnd_reg_q;
                reg_we    = op_modifies(op_q);
                flag_z_we = (op_q == OP_TST);
                flag_c_we = (op_q == OP_LDC);
            end
            ST_MEM_RD: mem_re = 1'b1;
            ST_MEM_WR: mem_we = 1'b1;
            ST_MEM_FIN: begin
                flag_z_we = (op_q == OP_TST);
                flag_c_we = (op_q == OP_LDC);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_re,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              reg_we,
    input logic              flag_z_we,
    input logic              flag_c_we
);
    logic [3:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cyc <= '0;
        else if (busy)   cyc <= done ? 4'd0 : cyc + 4'd1;
        else             cyc <= start ? 4'd1 : 4'd0;
    end

    // R5, R6, R7: only the three legal lengths end an operation
    assert_done_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc == 4'd2 || cyc == 4'd6 || cyc == 4'd8));
    assert_rd_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (cyc == 4'd3));
    assert_wr_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (cyc == 4'd6));
    assert_wr_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == $past(mem_addr, 3)));
    assert_no_wr_short_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cyc == 4'd6) |-> !mem_we);
    assert_flag_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_z_we || flag_c_we) |-> (!reg_we && !mem_we));
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_zwe_in_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z_we |-> done);
    assert_cwe_in_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flag_c_we |-> done);
    assert_flag_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_z_we && flag_c_we));
    assert_regwe_in_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> done);
endmodule

bind bitop_unit bitop_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .reg_we    (reg_we),
    .flag_z_we (flag_z_we),
    .flag_c_we (flag_c_we)
);

// File: tb/test_bitop_unit.sv
module test_bitop_unit;
    localparam int CLK_PERIOD = 10;
    localparam int RSEL_W = 4;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [2:0]        op_code = '0;
    logic [1:0]        opnd_loc = '0;
    logic              idx_from_reg = 1'b0;
    logic [2:0]        idx_imm = '0;
    logic [RSEL_W-1:0] idx_reg_sel = '0;
    logic [RSEL_W-1:0] opnd_reg_sel = '0;
    logic [7:0]        abs_addr = '0;
    logic [RSEL_W-1:0] reg_raddr;
    logic [ADDR_W-1:0] reg_rdata;
    logic              reg_we;
    logic [RSEL_W-1:0] reg_waddr;
    logic [7:0]        reg_wdata;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_re, mem_we;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata = '0;
    logic              flag_z, flag_z_we, flag_c, flag_c_we, done;

    logic [ADDR_W-1:0] regs [16];
    logic [7:0]        mem  [256];

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitop_unit #(.RSEL_W(RSEL_W), .ADDR_W(ADDR_W)) i_bitop_unit (.*);

    assign reg_rdata = regs[reg_raddr];

    always @(posedge clk) begin
        if (reg_we) regs[reg_waddr][7:0] <= reg_wdata;
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    end

    // Results of the last operation
    int          r_cyc, r_nre, r_nwe, r_nregwe, r_re_cyc, r_we_cyc, r_stray, r_extra;
    logic [15:0] r_re_addr, r_we_addr;
    logic        r_zwe, r_z, r_cwe, r_c, r_done_after;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [1:0] loc, input logic ifr,
                          input logic [2:0] imm, input logic [3:0] ireg, input logic [3:0] oreg,
                          input logic [7:0] abs, input logic hammer);
        r_nre = 0; r_nwe = 0; r_nregwe = 0; r_stray = 0; r_extra = 0;
        r_re_cyc = 0; r_we_cyc = 0; r_re_addr = '0; r_we_addr = '0;
        @(negedge clk);
        op_code = op; opnd_loc = loc; idx_from_reg = ifr; idx_imm = imm;
        idx_reg_sel = ireg; opnd_reg_sel = oreg; abs_addr = abs; start = 1'b1;
        @(negedge clk);
        if (hammer) begin
            op_code = 3'd2; idx_imm = 3'd5; opnd_loc = 2'd0;
        end else begin
            start = 1'b0;
        end
        r_cyc = 1;
        forever begin
            if (mem_re) begin r_nre++; r_re_cyc = r_cyc; r_re_addr = mem_addr; end
            if (mem_we) begin r_nwe++; r_we_cyc = r_cyc; r_we_addr = mem_addr; end
            if (reg_we) r_nregwe++;
            if (done) break;
            if (flag_z_we || flag_c_we) r_stray++;
            if (r_cyc > 20) break;
            @(negedge clk);
            r_cyc++;
        end
        r_zwe = flag_z_we; r_z = flag_z; r_cwe = flag_c_we; r_c = flag_c;
        start = 1'b0;
        @(negedge clk);
        r_done_after = done;
        for (int k = 0; k < 4; k++) begin
            if (done) r_extra++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R12 done", done, 0);
        chk("R12 reg_we", reg_we, 0);
        chk("R12 mem_re", mem_re, 0);
        chk("R12 mem_we", mem_we, 0);
        chk("R12 flag enables", {flag_z_we, flag_c_we}, 0);
    endtask

    task automatic t_reg_set;
        regs[3] = 16'h55A5;
        run_op(3'd0, 2'd0, 1'b0, 3'd1, 4'd0, 4'd3, 8'h00, 1'b0);
        chk("R1 reg set byte", regs[3][7:0], 8'hA7);
        chk("R1 reg upper untouched", regs[3][15:8], 8'h55);
        chk("R5 reg set length", r_cyc, 2);
        chk("R5 reg write count", r_nregwe, 1);
        chk("R4 set flag enables", {r_zwe, r_cwe}, 0);
        chk("R11 done one cycle", r_done_after, 0);
    endtask

    task automatic t_reg_clr_regidx;
        regs[5] = 16'h00FA; // low 3 bits give 2 (R8)
        run_op(3'd1, 2'd0, 1'b1, 3'd7, 4'd5, 4'd3, 8'h00, 1'b0);
        chk("R8 reg index low bits", regs[3][7:0], 8'hA3);
        chk("R4 clr flag enables", {r_zwe, r_cwe}, 0);
        chk("R5 reg clr length", r_cyc, 2);
    endtask

    task automatic t_reg_inv;
        run_op(3'd2, 2'd0, 1'b0, 3'd7, 4'd0, 4'd3, 8'h00, 1'b0);
        chk("R1 reg inv bit7", regs[3][7:0], 8'h23);
        chk("R4 inv flag enables", {r_zwe, r_cwe}, 0);
    endtask

    task automatic t_reg_tst;
        run_op(3'd3, 2'd0, 1'b0, 3'd5, 4'd0, 4'd3, 8'h00, 1'b0);
        chk("R2 tst z_we", r_zwe, 1);
        chk("R2 tst z for set bit", r_z, 0);
        chk("R2 tst no c_we", r_cwe, 0);
        chk("R2 tst no reg write", r_nregwe, 0);
        chk("R11 no stray flag enable", r_stray, 0);
        run_op(3'd3, 2'd0, 1'b0, 3'd6, 4'd0, 4'd3, 8'h00, 1'b0);
        chk("R2 tst z for clear bit", r_z, 1);
        chk("R2 tst operand kept", regs[3][7:0], 8'h23);
        chk("R5 reg tst length", r_cyc, 2);
    endtask

    task automatic t_reg_ldc;
        run_op(3'd4, 2'd0, 1'b0, 3'd0, 4'd0, 4'd3, 8'h00, 1'b0);
        chk("R3 ldc c_we", r_cwe, 1);
        chk("R3 ldc c value", r_c, 1);
        chk("R3 ldc no z_we", r_zwe, 0);
        chk("R3 ldc no reg write", r_nregwe, 0);
    endtask

    task automatic t_mem_ptr_set;
        regs[7] = 16'h1234; mem[8'h34] = 8'h10;
        run_op(3'd0, 2'd1, 1'b0, 3'd0, 4'd0, 4'd7, 8'h00, 1'b0);
        chk("R6 mem set byte", mem[8'h34], 8'h11);
        chk("R6 mem set length", r_cyc, 8);
        chk("R6 read count", r_nre, 1);
        chk("R6 write count", r_nwe, 1);
        chk("R6 read cycle", r_re_cyc, 3);
        chk("R6 write cycle", r_we_cyc, 6);
        chk("R9 pointer address", r_re_addr, 16'h1234);
        chk("R6 same address", r_we_addr, 16'h1234);
        chk("R4 mem set flag enables", {r_zwe, r_cwe}, 0);
        chk("R11 mem done one cycle", r_done_after, 0);
    endtask

    task automatic t_mem_abs_inv;
        regs[5] = 16'hFF0B; mem[8'h56] = 8'hFF;
        run_op(3'd2, 2'd2, 1'b1, 3'd0, 4'd5, 4'd0, 8'h56, 1'b0);
        chk("R1 mem inv via reg index (R8)", mem[8'h56], 8'hF7);
        chk("R9 absolute read address", r_re_addr, 16'hFF56);
        chk("R9 absolute write address", r_we_addr, 16'hFF56);
        chk("R6 mem inv length", r_cyc, 8);
    endtask

    task automatic t_mem_abs_clr;
        run_op(3'd1, 2'd2, 1'b0, 3'd7, 4'd0, 4'd0, 8'h56, 1'b0);
        chk("R1 mem clr bit7", mem[8'h56], 8'h77);
        chk("R6 mem clr write count", r_nwe, 1);
    endtask

    task automatic t_mem_ptr_tst;
        regs[8] = 16'h2280; mem[8'h80] = 8'h40;
        run_op(3'd3, 2'd1, 1'b0, 3'd6, 4'd0, 4'd8, 8'h00, 1'b0);
        chk("R7 mem tst length", r_cyc, 6);
        chk("R7 mem tst reads", r_nre, 1);
        chk("R7 mem tst read cycle", r_re_cyc, 3);
        chk("R7 mem tst no write", r_nwe, 0);
        chk("R2 mem tst z", r_z, 0);
        chk("R2 mem tst z_we", r_zwe, 1);
        chk("R2 mem tst byte kept", mem[8'h80], 8'h40);
        chk("R9 mem tst pointer", r_re_addr, 16'h2280);
    endtask

    task automatic t_mem_abs_ldc;
        mem[8'h90] = 8'h01;
        run_op(3'd4, 2'd2, 1'b0, 3'd0, 4'd0, 4'd0, 8'h90, 1'b0);
        chk("R7 mem ldc length", r_cyc, 6);
        chk("R7 mem ldc no write", r_nwe, 0);
        chk("R3 mem ldc c", r_c, 1);
        chk("R3 mem ldc c_we", r_cwe, 1);
        chk("R9 mem ldc address", r_re_addr, 16'hFF90);
        chk("R11 no stray flag enable", r_stray, 0);
    endtask

    task automatic t_busy_start;
        regs[2] = 16'h0000;
        run_op(3'd0, 2'd0, 1'b0, 3'd4, 4'd0, 4'd2, 8'h00, 1'b1);
        chk("R10 result of first request", regs[2][7:0], 8'h10);
        chk("R10 length unchanged", r_cyc, 2);
        chk("R10 single write", r_nregwe, 1);
        chk("R10 no second done", r_extra + r_done_after, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = '0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_reg_set;
        t_reg_clr_regidx;
        t_reg_inv;
        t_reg_tst;
        t_reg_ldc;
        t_mem_ptr_set;
        t_mem_abs_inv;
        t_mem_abs_clr;
        t_mem_ptr_tst;
        t_mem_abs_ldc;
        t_busy_start;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule